// File: doc/BRIEF.md
# Six-Instruction Control Decoder

This block turns one 32-bit instruction word into the full set of control lines that a single-cycle datapath needs to execute it. It recognises a small subset of a classic load/store instruction set: a register-register add, an OR with an immediate, a word load, a word store, a branch on equality and the no-operation. The decode is built in two stages. The first stage is a matching plane that compares the opcode field, and for the register form also the function field, against each supported encoding and raises exactly one product term. The second stage is a combining plane in which each control output is the OR of the product terms that need it.

The decoder holds no state and takes no clock. Its outputs follow the instruction word within the same cycle, so the surrounding datapath fetches the word, presents it here and uses the control lines before the next edge. Every word that does not match a supported encoding, including the all-zero word, produces the inactive control vector. Such a word writes no register, writes no memory and takes no branch.

Top module: `ctl_decode6`

## Requirements
- R1: The all-zero word gives every control output at 0, with alu_op = 2'b00.
- R2: Opcode 6'h00 with function field 6'h20 (add) gives reg_wr=1 and dst_is_rd=1, with alu_src_imm=0, alu_op=2'b00 (add) and no memory or branch activity.
- R3: Opcode 6'h0D (OR immediate) gives reg_wr=1, dst_is_rd=0, alu_src_imm=1, alu_op=2'b10 (OR) and imm_signed=0 (zero extension).
- R4: Opcode 6'h23 (load word) gives reg_wr=1, dst_is_rd=0, alu_src_imm=1, alu_op=2'b00, mem_rd=1, mem_to_reg=1 and imm_signed=1.
- R5: Opcode 6'h2B (store word) gives mem_wr=1, alu_src_imm=1, alu_op=2'b00 and imm_signed=1, with reg_wr=0 and mem_rd=0.
- R6: Opcode 6'h04 (branch on equal) gives branch=1, alu_op=2'b01 (subtract), alu_src_imm=0 and imm_signed=1, with reg_wr=0 and mem_wr=0.
- R7: Any other opcode, and opcode 6'h00 with a function field other than 6'h20, gives the same inactive vector as R1.
- R8: imm_signed is 1 only for load, store and branch, and it is 0 for every other word, the OR immediate included.
- R9: Only bits [31:26] and [5:0] affect the outputs. The register, shift and immediate fields have no effect.
- R10: The outputs depend only on the present instruction word. The same word gives the same vector whatever came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| dst_is_rd | output | 1 | 1: write destination is bits [15:11]; 0: bits [20:16] |
| alu_src_imm | output | 1 | 1: ALU second operand is the extended immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | 1: register write data comes from memory |
| branch | output | 1 | Branch on ALU zero result |
| imm_signed | output | 1 | 1: sign-extend the 16-bit immediate; 0: zero-extend |

## Verification
The bench builds the decoder with its default parameters, the 32-bit word and the 2-bit ALU code. With these the whole decode space is small enough to sweep: all 64 opcodes and, under opcode zero, all 64 function codes. Each sweep point carries varying register and immediate fields. That makes every unrecognised encoding next to a legal one reachable, and it shows that the non-decoded fields leave the vector unchanged.

// File: rtl/ctl_decode6_pkg.sv
package ctl_decode6_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned FUN_W    = 6;
  localparam int unsigned ALUOP_W  = 2;
  localparam int unsigned OPC_LSB  = WORD_W - OPC_W;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BREQ = 6'h04;
  localparam logic [FUN_W-1:0] FUN_ADD  = 6'h20;

  localparam logic [ALUOP_W-1:0] ALU_ADD = 2'b00;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 2'b01;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 2'b10;

  // product terms of the matching plane
  typedef enum int unsigned {
    T_ADD  = 0,
    T_ORI  = 1,
    T_LOAD = 2,
    T_STOR = 3,
    T_BREQ = 4
  } term_e;
  localparam int unsigned NUM_TERMS = 5;

  // positions inside the flat control vector
  localparam int unsigned C_DST   = 0;
  localparam int unsigned C_ASRC  = 1;
  localparam int unsigned C_RWR   = 2;
  localparam int unsigned C_MRD   = 3;
  localparam int unsigned C_MWR   = 4;
  localparam int unsigned C_M2R   = 5;
  localparam int unsigned C_BR    = 6;
  localparam int unsigned C_SEXT  = 7;
  localparam int unsigned C_ALU0  = 8;
  localparam int unsigned NUM_CTL = C_ALU0 + ALUOP_W;

  typedef logic [NUM_TERMS-1:0] terms_t;
  typedef logic [NUM_CTL-1:0]   ctl_vec_t;

  // opcode each term matches
  function automatic logic [OPC_W-1:0] term_opcode(int unsigned t);
    case (t)
      T_ADD:   term_opcode = OPC_REG;
      T_ORI:   term_opcode = OPC_ORI;
      T_LOAD:  term_opcode = OPC_LOAD;
      T_STOR:  term_opcode = OPC_STOR;
      default: term_opcode = OPC_BREQ;
    endcase
  endfunction

  // whether the term also qualifies on the function field
  function automatic logic term_uses_fun(int unsigned t);
    term_uses_fun = (t == T_ADD);
  endfunction

  // controls raised by a term
  function automatic ctl_vec_t term_row(int unsigned t);
    ctl_vec_t v;
    v = '0;
    case (t)
      T_ADD: begin
        v[C_DST] = 1'b1;
        v[C_RWR] = 1'b1;
        v[C_ALU0 +: ALUOP_W] = ALU_ADD;
      end
      T_ORI: begin
        v[C_ASRC] = 1'b1;
        v[C_RWR]  = 1'b1;
        v[C_ALU0 +: ALUOP_W] = ALU_OR;
      end
      T_LOAD: begin
        v[C_ASRC] = 1'b1;
        v[C_RWR]  = 1'b1;
        v[C_MRD]  = 1'b1;
        v[C_M2R]  = 1'b1;
        v[C_SEXT] = 1'b1;
        v[C_ALU0 +: ALUOP_W] = ALU_ADD;
      end
      T_STOR: begin
        v[C_ASRC] = 1'b1;
        v[C_MWR]  = 1'b1;
        v[C_SEXT] = 1'b1;
        v[C_ALU0 +: ALUOP_W] = ALU_ADD;
      end
      default: begin
        v[C_BR]   = 1'b1;
        v[C_SEXT] = 1'b1;
        v[C_ALU0 +: ALUOP_W] = ALU_SUB;
      end
    endcase
    term_row = v;
  endfunction

  // column of the combining plane: which terms feed a control bit
  function automatic terms_t ctl_column(int unsigned c);
    terms_t m;
    ctl_vec_t r;
    m = '0;
    for (int unsigned t = 0; t < NUM_TERMS; t++) begin
      r = term_row(t);
      m[t] = r[c];
    end
    ctl_column = m;
  endfunction

endpackage

// File: rtl/ctl_decode6_fields.sv
module ctl_decode6_fields
  import ctl_decode6_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [OPC_W-1:0]  opc_o,
  output logic [FUN_W-1:0]  fun_o
);
  // register, shift and immediate fields are not decoded
  logic unused_mid;
  assign unused_mid = ^word_i[OPC_LSB-1:FUN_W];

  assign opc_o = word_i[WORD_W-1:OPC_LSB];
  assign fun_o = word_i[FUN_W-1:0];
endmodule

// File: rtl/ctl_decode6_match.sv
module ctl_decode6_match
  import ctl_decode6_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FUN_W-1:0] fun_i,
  output terms_t           hit_o
);
  logic fun_is_add;
  assign fun_is_add = (fun_i == FUN_ADD);

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    localparam logic [OPC_W-1:0] MATCH_OPC = term_opcode(t);
    localparam logic             NEED_FUN  = term_uses_fun(t);
    logic opc_hit;
    assign opc_hit  = (opc_i == MATCH_OPC);
    assign hit_o[t] = opc_hit & (~NEED_FUN | fun_is_add);
  end
endmodule

// File: rtl/ctl_decode6_combine.sv
module ctl_decode6_combine
  import ctl_decode6_pkg::*;
(
  input  terms_t   hit_i,
  output ctl_vec_t ctl_o
);
  for (genvar c = 0; c < NUM_CTL; c++) begin : g_col
    localparam terms_t COL = ctl_column(c);
    assign ctl_o[c] = |(hit_i & COL);
  end
endmodule

// File: rtl/ctl_decode6.sv
module ctl_decode6
  import ctl_decode6_pkg::*;
(
  input  logic [31:0] instr_word,
  output logic        dst_is_rd,
  output logic        alu_src_imm,
  output logic [1:0]  alu_op,
  output logic        reg_wr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        mem_to_reg,
  output logic        branch,
  output logic        imm_signed
);
  logic [OPC_W-1:0] opc;
  logic [FUN_W-1:0] fun;
  terms_t           hits;
  ctl_vec_t         ctl;

  ctl_decode6_fields u_fields (
    .word_i (instr_word),
    .opc_o  (opc),
    .fun_o  (fun)
  );

  ctl_decode6_match u_match (
    .opc_i (opc),
    .fun_i (fun),
    .hit_o (hits)
  );

  ctl_decode6_combine u_combine (
    .hit_i (hits),
    .ctl_o (ctl)
  );

  assign dst_is_rd   = ctl[C_DST];
  assign alu_src_imm = ctl[C_ASRC];
  assign reg_wr      = ctl[C_RWR];
  assign mem_rd      = ctl[C_MRD];
  assign mem_wr      = ctl[C_MWR];
  assign mem_to_reg  = ctl[C_M2R];
  assign branch      = ctl[C_BR];
  assign imm_signed  = ctl[C_SEXT];
  assign alu_op      = ctl[C_ALU0 +: ALUOP_W];
endmodule

// File: rtl/ctl_decode6_chk.sv
module ctl_decode6_chk (
  input logic [31:0] instr_word,
  input logic        dst_is_rd,
  input logic        alu_src_imm,
  input logic [1:0]  alu_op,
  input logic        reg_wr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        mem_to_reg,
  input logic        branch,
  input logic        imm_signed
);
  logic [5:0] opc;
  assign opc = instr_word[31:26];

  always_comb begin
    // R1
    zero_word_idle_chk: assert (instr_word != 32'h0 ||
      {dst_is_rd, alu_src_imm, alu_op, reg_wr, mem_rd, mem_wr, mem_to_reg, branch, imm_signed} == '0);
    // R5
    store_no_regwr_chk: assert (!mem_wr || (!reg_wr && !mem_rd && opc == 6'h2B));
    // R6
    branch_no_writes_chk: assert (!branch || (!reg_wr && !mem_wr && alu_op == 2'b01));
    // R4
    load_path_chk: assert (mem_to_reg == mem_rd && (!mem_rd || (reg_wr && opc == 6'h23)));
    // R8
    ext_mode_chk: assert (imm_signed == (opc == 6'h23 || opc == 6'h2B || opc == 6'h04));
    // R2
    rd_dest_chk: assert (!dst_is_rd || (reg_wr && !alu_src_imm && opc == 6'h00));
    // R7
    one_action_chk: assert ($onehot0({reg_wr, mem_wr, branch}));
  end
endmodule

bind ctl_decode6 ctl_decode6_chk u_chk (.*);

// File: tb/ctl_decode6_tb_top.sv
module ctl_decode6_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] instr_word = 32'h0;
  logic dst_is_rd, alu_src_imm, reg_wr, mem_rd, mem_wr, mem_to_reg, branch, imm_signed;
  logic [1:0] alu_op;

  ctl_decode6 dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected vector: {dst, asrc, alu_op[1:0], rwr, mrd, mwr, m2r, br, sext}
  function automatic logic [9:0] model(logic [31:0] w, output string tag);
    logic [5:0] op;
    op = w[31:26];
    tag = "R7";
    model = 10'b0;
    if (w == 32'h0) tag = "R1";
    else if (op == 6'h00 && w[5:0] == 6'h20) begin model = 10'b1000100000; tag = "R2"; end
    else if (op == 6'h0D) begin model = 10'b0110100000; tag = "R3"; end
    else if (op == 6'h23) begin model = 10'b0100110101; tag = "R4"; end
    else if (op == 6'h2B) begin model = 10'b0100001001; tag = "R5"; end
    else if (op == 6'h04) begin model = 10'b0001000011; tag = "R6"; end
  endfunction

  task automatic check_word(string note);
    string tag;
    logic [9:0] exp, got;
    exp = model(instr_word, tag);
    got = {dst_is_rd, alu_src_imm, alu_op, reg_wr, mem_rd, mem_wr, mem_to_reg, branch, imm_signed};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s word=%h got=%b expected=%b", tag, note, instr_word, got, exp);
    end
    // R8 extension mode checked on its own
    checks++;
    if (imm_signed !== exp[0]) begin
      errors++;
      $display("FAIL R8 word=%h imm_signed got=%b expected=%b", instr_word, imm_signed, exp[0]);
    end
  endtask

  task automatic apply(logic [31:0] w, string note);
    @(posedge clk); #1;
    instr_word = w;
    @(negedge clk);
    check_word(note);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_word("reset-state zero word");
    // named encodings
    apply(32'h0000_0000, "R1 nop");
    apply(32'h0043_0820, "R2 add");
    apply(32'h3422_00FF, "R3 ori");
    apply(32'h8C22_FFFC, "R4 lw");
    apply(32'hAC22_0004, "R5 sw");
    apply(32'h1022_FFFE, "R6 beq");
    apply(32'h0043_0822, "R7 sub funct");
    apply(32'h2022_0001, "R7 addi opcode");
    apply(32'hFFFF_FFFF, "R7 all ones");
    apply(32'h0000_0020, "R2 add zero regs");
    // R9: sweep all opcodes with varying middle fields
    for (int op = 0; op < 64; op++) begin
      seed = seed * 1103515245 + 12345;
      apply({op[5:0], seed[25:6], (op == 0) ? 6'h20 : seed[31:26]}, "R9 opcode sweep");
    end
    // R7/R9: sweep function codes under opcode zero
    for (int fn = 0; fn < 64; fn++) begin
      seed = seed * 1103515245 + 12345;
      apply({6'h00, seed[29:10], fn[5:0]}, "R9 funct sweep");
    end
    // R10: same word after different predecessors gives the same vector
    for (int k = 0; k < 6; k++) begin
      seed = seed * 1103515245 + 12345;
      apply(seed, "R10 predecessor");
      apply(32'h3422_00FF, "R10 ori repeat");
      apply(32'h1022_FFFE, "R10 beq repeat");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired got=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule